// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sequences a small system through four power states: run, sleep, stop and standby. Software selects a target state on a mode-request bus. The controller acts on that request only when it sees a one-cycle enter strobe, which plays the part of a wait-for-interrupt instruction. The controller then drives the clock-enable, retention, power-down and reset-request lines that belong to the chosen state. Three wake inputs bring the system back to run: a GPIO interrupt, an RTC alarm and a timer event. Each input has its own enable bit.

The three low-power states keep different amounts of context, and each one returns to run by a different path:
- **Sleep.** Only the CPU clock stops, and a wake returns to run on the next edge.
- **Stop.** All clocks are gated and RAM is retained. On wake the clock tree comes back on its fallback oscillator. A fixed settle interval is counted, and then a sticky request asks software to restore the full clock configuration.
- **Standby.** Power is removed. On wake a system reset is requested for a fixed number of cycles, and a sticky flag records standby as the reset cause.

The controller also keeps these readable values:
- a flag for the first wake source that fired,
- an error flag for a refused entry,
- the wake latency, in cycles, of the most recent exit.

Top module: `lp_mode_ctrl`

## Requirements
- R1: After reset the controller is in run: CPU clock enable = 1, peripheral clock enable = 1, retention, power-down and reset request = 0. All flags are 0 and the latency is 0. A mode request without `enter_i` leaves the controller in run.
- R2: `enter_i` with `mode_req_i` = 1 (sleep) gives CPU clock enable 0 and peripheral clock enable 1 from the next cycle. Retention, power-down and reset request stay 0.
- R3: `enter_i` with `mode_req_i` = 2 (stop) and at least one enabled wake source gives both clock enables 0 and retention 1 from the next cycle.
- R4: `enter_i` with `mode_req_i` = 3 (standby) and at least one enabled wake source gives power-down 1 with both clock enables and retention 0. A wake from standby asserts only the reset request for RST_CYC cycles and then returns to run.
- R5: Wake bit 0 is GPIO, bit 1 is RTC and bit 2 is timer. An event is accepted only when its bit in `wake_en_i` is set. Events that are not enabled leave the low-power state and the wake-source flag unchanged. A sleep entered with no enable bit set stays asleep.
- R6: On an accepted wake, `wake_src_o` records the accepted source as a one-hot value. If several sources fire in the same cycle, the lowest bit wins. A later wake does not overwrite a recorded source until the flags are cleared.
- R7: `enter_i` requesting stop or standby while `wake_en_i` is 0 is refused. The controller stays in run and sets `err_o`.
- R8: A wake from stop holds both clocks off with retention on for WAKE_CYC cycles, then returns to run. It also sets `restore_req_o`, which stays 1 until `restore_ack_i` is pulsed.
- R9: A wake from standby sets `rst_cause_stby_o`. The flag stays 1 through later mode cycles until the flags are cleared.
- R10: After each return to run, `latency_o` holds the cycles from the accepting edge up to and including the edge that entered run: 1 from sleep, 1+WAKE_CYC from stop, 1+RST_CYC from standby.
- R11: A `flags_clr_i` pulse clears `wake_src_o`, `rst_cause_stby_o` and `err_o`.
- R12: `mode_req_i` = 0 (run) with `enter_i` leaves the controller in run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_req_i | input | 2 | Target state: 0 run, 1 sleep, 2 stop, 3 standby |
| enter_i | input | 1 | Entry strobe |
| wake_en_i | input | N_WAKE | Per-source wake enable (bit0 GPIO, bit1 RTC, bit2 timer) |
| wake_evt_i | input | N_WAKE | Wake events, same bit order |
| flags_clr_i | input | 1 | Clears wake-source, reset-cause and error flags |
| restore_ack_i | input | 1 | Software acknowledges clock restoration |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| periph_clk_en_o | output | 1 | Peripheral clock enable |
| retain_o | output | 1 | RAM/state retention |
| pwr_down_o | output | 1 | Power-down of the core domain |
| sys_rst_o | output | 1 | System reset request |
| restore_req_o | output | 1 | Clock tree is on fallback and must be restored |
| wake_src_o | output | N_WAKE | Sticky first wake source, one-hot |
| rst_cause_stby_o | output | 1 | Sticky standby reset cause |
| err_o | output | 1 | Sticky refused-entry error |
| latency_o | output | LAT_W | Wake latency of the last exit, in cycles |

## Verification
The hardest case to reach from the ports is a wake event that arrives while its enable bit is clear. To show that the event was ignored, the controller must first be parked in each low-power state. The bench then presents the event and confirms both that the clock and power outputs hold and that no source was recorded. Only after that does it release the state with an enabled event.

To cover this, the bench sweeps every target state against every enable mask and every event mask. From the two masks it derives the accepted source, the expected one-hot flag and the exact cycle counts of the stop settle and the standby reset. Separate sequences then show:
- a recorded source surviving a second wake,
- the standby cause surviving later sleep cycles,
- the restore request persisting until it is acknowledged.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    REQ_RUN   = 2'd0,
    REQ_SLEEP = 2'd1,
    REQ_STOP  = 2'd2,
    REQ_STBY  = 2'd3
  } lp_req_e;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_SLEEP  = 3'd1,
    ST_STOP   = 3'd2,
    ST_STBY   = 3'd3,
    ST_RESUME = 3'd4,
    ST_RST    = 3'd5
  } lp_state_e;

  typedef struct packed {
    logic cpu_en;
    logic per_en;
    logic retain;
    logic pwr_dn;
    logic rst;
  } lp_ctl_t;
endpackage

// File: rtl/lpm_wake_sel.sv
module lpm_wake_sel #(
  parameter int N_WAKE = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              armed_i,
  input  logic [N_WAKE-1:0] evt_i,
  input  logic [N_WAKE-1:0] en_i,
  input  logic              clr_i,
  output logic              accept_o,
  output logic [N_WAKE-1:0] src_o
);
  logic [N_WAKE-1:0] hit, first;
  logic              found;

  assign hit      = evt_i & en_i & {N_WAKE{armed_i}};
  assign accept_o = |hit;

  // lowest index wins
  always_comb begin
    first = '0;
    found = 1'b0;
    for (int i = 0; i < N_WAKE; i++) begin
      if (hit[i] && !found) begin
        first[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_o <= '0;
    else if (accept_o && (src_o == '0 || clr_i)) src_o <= first;
    else if (clr_i) src_o <= '0;
  end

  // R6
  src_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(src_o));

  // R5
  no_src_wo_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_i || (evt_i & en_i) == '0) && !clr_i |=> $stable(src_o));
endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
  import lpm_pkg::*;
#(
  parameter int WAKE_CYC = 4,
  parameter int RST_CYC  = 6,
  parameter int LAT_W    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enter_i,
  input  logic [1:0]       mode_i,
  input  logic             any_en_i,
  input  logic             wake_i,
  input  logic             clr_i,
  input  logic             ack_i,
  output lp_state_e        state_o,
  output logic             armed_o,
  output logic [LAT_W-1:0] latency_o,
  output logic             err_o,
  output logic             rcause_o,
  output logic             restore_o
);
  localparam int MAXC  = (WAKE_CYC > RST_CYC) ? WAKE_CYC : RST_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  lp_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             reject, wake_stop, wake_stby;

  assign armed_o   = (state_q == ST_SLEEP) || (state_q == ST_STOP) || (state_q == ST_STBY);
  assign reject    = (state_q == ST_RUN) && enter_i && !any_en_i &&
                     (mode_i == REQ_STOP || mode_i == REQ_STBY);
  assign wake_stop = (state_q == ST_STOP) && wake_i;
  assign wake_stby = (state_q == ST_STBY) && wake_i;
  assign state_o   = state_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_RUN: if (enter_i && !reject) begin
        unique case (mode_i)
          REQ_SLEEP: state_d = ST_SLEEP;
          REQ_STOP:  state_d = ST_STOP;
          REQ_STBY:  state_d = ST_STBY;
          default:   state_d = ST_RUN;
        endcase
      end
      ST_SLEEP: if (wake_i) state_d = ST_RUN;
      ST_STOP: if (wake_i) begin
        state_d = ST_RESUME;
        cnt_d   = CNT_W'(WAKE_CYC);
      end
      ST_STBY: if (wake_i) begin
        state_d = ST_RST;
        cnt_d   = CNT_W'(RST_CYC);
      end
      ST_RESUME, ST_RST: begin
        if (cnt_q <= CNT_W'(1)) state_d = ST_RUN;
        else cnt_d = cnt_q - 1'b1;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_RUN;
      cnt_q     <= '0;
      latency_o <= '0;
      err_o     <= 1'b0;
      rcause_o  <= 1'b0;
      restore_o <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (armed_o && wake_i) latency_o <= LAT_W'(1);
      else if ((state_q == ST_RESUME || state_q == ST_RST) && latency_o != '1)
        latency_o <= latency_o + 1'b1;
      if (reject) err_o <= 1'b1;
      else if (clr_i) err_o <= 1'b0;
      if (wake_stby) rcause_o <= 1'b1;
      else if (clr_i) rcause_o <= 1'b0;
      if (wake_stop) restore_o <= 1'b1;
      else if (ack_i) restore_o <= 1'b0;
    end
  end

  // R1
  no_entry_wo_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_RUN && !enter_i |=> state_q == ST_RUN);

  // R7
  reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_RUN && enter_i && !any_en_i && mode_i[1] |=> state_q == ST_RUN && err_o);

  // R5
  hold_asleep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_o && !wake_i |=> state_q == $past(state_q));

  // R4
  rst_from_stby_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_RST) |-> $past(state_q == ST_STBY) && rcause_o);

  // R8
  restore_from_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(restore_o) |-> $past(state_q == ST_STOP));
endmodule

// File: rtl/lpm_ctl_dec.sv
module lpm_ctl_dec
  import lpm_pkg::*;
(
  input  lp_state_e state_i,
  output lp_ctl_t   ctl_o
);
  always_comb begin
    ctl_o = '0;
    unique case (state_i)
      ST_RUN:    begin ctl_o.cpu_en = 1'b1; ctl_o.per_en = 1'b1; end
      ST_SLEEP:  ctl_o.per_en = 1'b1;
      ST_STOP,
      ST_RESUME: ctl_o.retain = 1'b1;
      ST_STBY:   ctl_o.pwr_dn = 1'b1;
      ST_RST:    ctl_o.rst    = 1'b1;
      default:   ctl_o = '0;
    endcase
  end
endmodule

// File: rtl/lp_mode_ctrl.sv
module lp_mode_ctrl
  import lpm_pkg::*;
#(
  parameter int N_WAKE   = 3,
  parameter int WAKE_CYC = 4,
  parameter int RST_CYC  = 6,
  parameter int LAT_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_req_i,
  input  logic              enter_i,
  input  logic [N_WAKE-1:0] wake_en_i,
  input  logic [N_WAKE-1:0] wake_evt_i,
  input  logic              flags_clr_i,
  input  logic              restore_ack_i,
  output logic              cpu_clk_en_o,
  output logic              periph_clk_en_o,
  output logic              retain_o,
  output logic              pwr_down_o,
  output logic              sys_rst_o,
  output logic              restore_req_o,
  output logic [N_WAKE-1:0] wake_src_o,
  output logic              rst_cause_stby_o,
  output logic              err_o,
  output logic [LAT_W-1:0]  latency_o
);
  lp_state_e state;
  lp_ctl_t   ctl;
  logic      armed, accept;

  lpm_wake_sel #(.N_WAKE(N_WAKE)) u_wake (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .armed_i  (armed),
    .evt_i    (wake_evt_i),
    .en_i     (wake_en_i),
    .clr_i    (flags_clr_i),
    .accept_o (accept),
    .src_o    (wake_src_o)
  );

  lpm_seq #(.WAKE_CYC(WAKE_CYC), .RST_CYC(RST_CYC), .LAT_W(LAT_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .enter_i   (enter_i),
    .mode_i    (mode_req_i),
    .any_en_i  (|wake_en_i),
    .wake_i    (accept),
    .clr_i     (flags_clr_i),
    .ack_i     (restore_ack_i),
    .state_o   (state),
    .armed_o   (armed),
    .latency_o (latency_o),
    .err_o     (err_o),
    .rcause_o  (rst_cause_stby_o),
    .restore_o (restore_req_o)
  );

  lpm_ctl_dec u_dec (
    .state_i (state),
    .ctl_o   (ctl)
  );

  assign cpu_clk_en_o    = ctl.cpu_en;
  assign periph_clk_en_o = ctl.per_en;
  assign retain_o        = ctl.retain;
  assign pwr_down_o      = ctl.pwr_dn;
  assign sys_rst_o       = ctl.rst;

  // R4
  pd_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_down_o |-> !cpu_clk_en_o && !periph_clk_en_o && !retain_o && !sys_rst_o);
endmodule

// File: tb/sim_lp_mode_ctrl.sv
module sim_lp_mode_ctrl;
  localparam int NW = 3, WK = 4, RS = 6, LW = 8;
  localparam int C_RUN = 5'b11000, C_SLP = 5'b01000, C_STP = 5'b00100,
                 C_SBY = 5'b00010, C_RST = 5'b00001;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = '0;
  logic enter = 1'b0, clr = 1'b0, ack = 1'b0;
  logic [NW-1:0] wen = '0, wevt = '0;
  logic cpu_en, per_en, ret, pd, srst, rreq, rcause, err;
  logic [NW-1:0] src;
  logic [LW-1:0] lat;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lp_mode_ctrl #(.N_WAKE(NW), .WAKE_CYC(WK), .RST_CYC(RS), .LAT_W(LW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_req_i(mode), .enter_i(enter),
    .wake_en_i(wen), .wake_evt_i(wevt), .flags_clr_i(clr), .restore_ack_i(ack),
    .cpu_clk_en_o(cpu_en), .periph_clk_en_o(per_en), .retain_o(ret),
    .pwr_down_o(pd), .sys_rst_o(srst), .restore_req_o(rreq),
    .wake_src_o(src), .rst_cause_stby_o(rcause), .err_o(err), .latency_o(lat)
  );

  task automatic eq(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ctl();
    return {cpu_en, per_en, ret, pd, srst};
  endfunction

  function automatic int low1(input int m);
    for (int i = 0; i < NW; i++) if (m[i]) return 1 << i;
    return 0;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clear_all();
    clr = 1'b1; ack = 1'b1; tick(); clr = 1'b0; ack = 1'b0;
  endtask

  task automatic enter_mode(input int m, input int en);
    wen = NW'(en); mode = 2'(m); enter = 1'b1; tick(); enter = 1'b0;
  endtask

  task automatic wake(input int ev);
    wevt = NW'(ev); tick(); wevt = '0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=0 expected=1");
      finish_run();
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    eq("R1 reset ctl", ctl(), C_RUN);
    eq("R1 reset src", src, 0);
    eq("R1 reset err", err, 0);
    eq("R1 reset rcause", rcause, 0);
    eq("R1 reset restore", rreq, 0);
    eq("R1 reset latency", lat, 0);

    // R1: request without strobe
    mode = 2'd2; wen = 3'b111;
    repeat (5) tick();
    eq("R1 no strobe", ctl(), C_RUN);
    // R12: run request with strobe
    enter_mode(0, 7);
    tick();
    eq("R12 run request", ctl(), C_RUN);

    for (int m = 1; m <= 3; m++) begin
      for (int en = 0; en < 8; en++) begin
        for (int ev = 1; ev < 8; ev++) begin
          int hit, exp_ctl;
          clear_all();
          enter_mode(m, en);
          if (m > 1 && en == 0) begin
            eq("R7 refused stays run", ctl(), C_RUN);
            eq("R7 err set", err, 1);
            continue;
          end
          exp_ctl = (m == 1) ? C_SLP : (m == 2) ? C_STP : C_SBY;
          eq((m == 1) ? "R2 sleep ctl" : (m == 2) ? "R3 stop ctl" : "R4 standby ctl",
             ctl(), exp_ctl);
          hit = ev & en;
          wake(ev);
          if (hit == 0) begin
            int we;
            eq("R5 disabled event holds", ctl(), exp_ctl);
            eq("R5 disabled event no src", src, 0);
            we = (en == 0) ? 1 : en;
            wen = NW'(we);
            wake(we);
            hit = we;
          end
          if (m == 1) begin
            eq("R2 sleep wake to run", ctl(), C_RUN);
            eq("R10 sleep latency", lat, 1);
          end else if (m == 2) begin
            eq("R8 resume holds clocks", ctl(), C_STP);
            repeat (WK - 1) tick();
            eq("R8 resume last cycle", ctl(), C_STP);
            tick();
            eq("R8 stop back to run", ctl(), C_RUN);
            eq("R10 stop latency", lat, 1 + WK);
            eq("R8 restore req", rreq, 1);
          end else begin
            eq("R4 reset pulse", ctl(), C_RST);
            eq("R9 rcause set", rcause, 1);
            repeat (RS - 1) tick();
            eq("R4 reset last cycle", ctl(), C_RST);
            tick();
            eq("R4 standby back to run", ctl(), C_RUN);
            eq("R10 standby latency", lat, 1 + RS);
            eq("R8 no restore after standby", rreq, 0);
          end
          eq("R6 first source", src, low1(hit));
          eq("R7 no err on valid entry", err, 0);
        end
      end
    end

    // R6: recorded source not overwritten
    clear_all();
    enter_mode(1, 1); wake(1);
    enter_mode(1, 2); wake(2);
    eq("R6 kept first source", src, 1);

    // R9: cause survives later cycles
    clear_all();
    enter_mode(3, 4); wake(4);
    repeat (RS + 1) tick();
    enter_mode(1, 1); wake(1);
    enter_mode(1, 1); wake(1);
    eq("R9 rcause persists", rcause, 1);

    // R8: restore request until acknowledged
    enter_mode(2, 2); wake(2);
    repeat (WK + 3) tick();
    eq("R8 restore persists", rreq, 1);
    ack = 1'b1; tick(); ack = 1'b0;
    eq("R8 restore acked", rreq, 0);

    // R11: clear
    enter_mode(3, 0);
    eq("R11 err before clear", err, 1);
    clr = 1'b1; tick(); clr = 1'b0;
    eq("R11 src cleared", src, 0);
    eq("R11 rcause cleared", rcause, 0);
    eq("R11 err cleared", err, 0);

    done = 1'b1;
    finish_run();
  end
endmodule